// File: doc/BRIEF.md
# Edge-Triggered Set/Clear Flag

This block holds a single output bit that is driven high by an edge on a set input and driven low by an edge on a clear input. The edge that counts is chosen separately for each input: rising, falling, or either. Edges are found by comparing each input with a registered copy from the previous cycle. The output register changes on the clock edge that samples the transition.

An enable input decides whether input edges are heard at all. While the block is disabled, an idle policy field chooses what the output does: go low, go high, or keep its value. Two single-cycle force strobes can drive the output high or low at any time, whether the block is enabled or not.

The configuration fields are plain inputs that the surrounding register block holds. A new select value affects edge detection in the same cycle it appears.

Top module: `edge_sr_latch`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `outQ` to 0 and clears both delayed input copies.
- R2: With the block enabled and no force strobe, an edge on `setIn` of the kind chosen by `setEdgeSel` makes `outQ` 1 after the next clock edge. The encoding is 0 = rising, 1 = falling, 2 = either, 3 = none.
- R3: With the block enabled and no force strobe, an edge on `clrIn` of the kind chosen by `clrEdgeSel` makes `outQ` 0 after the next clock edge. It uses the same encoding as R2.
- R4: When a qualifying clear edge and a qualifying set edge are sampled in the same cycle, `outQ` becomes 0.
- R5: While `enable` is 0, input edges are ignored and `idlePolicy` decides the output: 0 or 3 drives `outQ` to 0, 1 drives it to 1, and 2 keeps its value.
- R6: `forceLow` drives `outQ` to 0 and `forceHigh` drives it to 1. Both act whatever the state of `enable`, the inputs and the policy. When both are asserted together, `forceLow` wins.
- R7: Edge qualification uses the select value present in the same cycle as the transition. A select change to falling that coincides with a rising edge ignores that edge. A select change to falling that coincides with a falling edge honours it.
- R8: With the block enabled, no force strobe and no qualifying edge, `outQ` keeps its value.
- R9: The delayed input copies track the inputs while the block is disabled. Re-enabling with an input already at a steady level produces no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | 1 = input edges are heard |
| setIn | input | 1 | Set input level |
| clrIn | input | 1 | Clear input level |
| setEdgeSel | input | 2 | Active edge of `setIn` (0 rise, 1 fall, 2 either, 3 none) |
| clrEdgeSel | input | 2 | Active edge of `clrIn` (same encoding) |
| idlePolicy | input | 2 | Output while disabled (0/3 low, 1 high, 2 keep) |
| forceHigh | input | 1 | Single-cycle strobe forcing the output to 1 |
| forceLow | input | 1 | Single-cycle strobe forcing the output to 0 |
| outQ | output | 1 | Registered output bit |

## Verification
The hardest situations to reach from the ports are those where a select value, the enable and both input levels all change in the very cycle that is scored. Two cases matter most: a select that flips as an edge arrives, and a re-enable onto a level that was already high. Each scored cycle in the sweep is preceded by a disabled setup cycle. That setup cycle uses a different select value, chosen previous levels and a policy that places the output at a chosen start value. As a result, every combination of select, policy, enable, force strobes and input transition is scored from both output states with the select changing at that instant. Short directed sequences then replay the select-change cases and the re-enable case one after the other.

// File: rtl/edge_sr_pkg.sv
package edge_sr_pkg;
  localparam int SEL_W  = 2;
  localparam int POL_W  = 2;
  localparam int CH_SET = 0;
  localparam int CH_CLR = 1;
  localparam int NUM_CH = 2;

  typedef enum logic [SEL_W-1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_OFF  = 2'd3
  } edgeSel_e;

  typedef enum logic [POL_W-1:0] {
    IDLE_LOW  = 2'd0,
    IDLE_HIGH = 2'd1,
    IDLE_KEEP = 2'd2,
    IDLE_ALT  = 2'd3
  } idlePol_e;

  typedef struct packed {
    logic loadHigh;
    logic loadLow;
  } outStrobe_t;
endpackage

// File: rtl/edge_sr_qualify.sv
module edge_sr_qualify
  import edge_sr_pkg::*;
(
  input  logic             curLvl,
  input  logic             prevLvl,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  logic rise;
  logic fall;

  assign rise = curLvl & ~prevLvl;
  assign fall = ~curLvl & prevLvl;

  always_comb begin
    case (edgeSel_e'(sel))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/edge_sr_ctrl.sv
module edge_sr_ctrl
  import edge_sr_pkg::*;
#(
  parameter int NCH = NUM_CH
) (
  input  logic                 enable,
  input  logic [NCH-1:0]       lvlIn,
  input  logic [NCH-1:0]       lvlDly,
  input  logic [NCH*SEL_W-1:0] selVec,
  input  logic [POL_W-1:0]     idlePolicy,
  input  logic                 forceHigh,
  input  logic                 forceLow,
  output outStrobe_t           strobe
);
  logic [NCH-1:0] hitVec;

  for (genvar g = 0; g < NCH; g++) begin : g_qual
    edge_sr_qualify u_qual (
      .curLvl (lvlIn[g]),
      .prevLvl(lvlDly[g]),
      .sel    (selVec[g*SEL_W +: SEL_W]),
      .hit    (hitVec[g])
    );
  end

  always_comb begin
    strobe = '0;
    if (forceLow) begin
      strobe.loadLow = 1'b1;
    end else if (forceHigh) begin
      strobe.loadHigh = 1'b1;
    end else if (!enable) begin
      case (idlePol_e'(idlePolicy))
        IDLE_HIGH: strobe.loadHigh = 1'b1;
        IDLE_KEEP: strobe = '0;
        default:   strobe.loadLow = 1'b1;
      endcase
    end else if (hitVec[CH_CLR]) begin
      strobe.loadLow = 1'b1;
    end else if (hitVec[CH_SET]) begin
      strobe.loadHigh = 1'b1;
    end
  end
endmodule

// File: rtl/edge_sr_datapath.sv
module edge_sr_datapath
  import edge_sr_pkg::*;
#(
  parameter int NCH = NUM_CH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] lvlIn,
  input  outStrobe_t     strobe,
  output logic [NCH-1:0] lvlDly,
  output logic           outQ
);
  for (genvar g = 0; g < NCH; g++) begin : g_dly
    always_ff @(posedge clk) begin
      if (rst) lvlDly[g] <= 1'b0;
      else     lvlDly[g] <= lvlIn[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  outQ <= 1'b0;
    else if (strobe.loadLow)  outQ <= 1'b0;
    else if (strobe.loadHigh) outQ <= 1'b1;
  end
endmodule

// File: rtl/edge_sr_latch.sv
module edge_sr_latch
  import edge_sr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             setIn,
  input  logic             clrIn,
  input  logic [SEL_W-1:0] setEdgeSel,
  input  logic [SEL_W-1:0] clrEdgeSel,
  input  logic [POL_W-1:0] idlePolicy,
  input  logic             forceHigh,
  input  logic             forceLow,
  output logic             outQ
);
  logic [NUM_CH-1:0]       lvlIn;
  logic [NUM_CH-1:0]       lvlDly;
  logic [NUM_CH*SEL_W-1:0] selVec;
  outStrobe_t              strobe;

  always_comb begin
    lvlIn  = '0;
    selVec = '0;
    lvlIn[CH_SET] = setIn;
    lvlIn[CH_CLR] = clrIn;
    selVec[CH_SET*SEL_W +: SEL_W] = setEdgeSel;
    selVec[CH_CLR*SEL_W +: SEL_W] = clrEdgeSel;
  end

  edge_sr_ctrl #(.NCH(NUM_CH)) u_ctrl (
    .enable    (enable),
    .lvlIn     (lvlIn),
    .lvlDly    (lvlDly),
    .selVec    (selVec),
    .idlePolicy(idlePolicy),
    .forceHigh (forceHigh),
    .forceLow  (forceLow),
    .strobe    (strobe)
  );

  edge_sr_datapath #(.NCH(NUM_CH)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .lvlIn (lvlIn),
    .strobe(strobe),
    .lvlDly(lvlDly),
    .outQ  (outQ)
  );
endmodule

// File: rtl/edge_sr_checker.sv
module edge_sr_checker
  import edge_sr_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             setIn,
  input logic             clrIn,
  input logic [SEL_W-1:0] setEdgeSel,
  input logic [SEL_W-1:0] clrEdgeSel,
  input logic [POL_W-1:0] idlePolicy,
  input logic             forceHigh,
  input logic             forceLow,
  input logic             outQ,
  input outStrobe_t       strobe
);
  logic quiet;
  assign quiet = !forceHigh && !forceLow;

  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
    forceLow |=> !outQ); // R6
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    forceHigh && !forceLow |=> outQ); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe)); // R6
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !enable && quiet && (idlePolicy == 2'd0 || idlePolicy == 2'd3) |=> !outQ); // R5
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !enable && quiet && idlePolicy == 2'd1 |=> outQ); // R5
  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
    !enable && quiet && idlePolicy == 2'd2 |=> $stable(outQ)); // R5
  AST_CLR_RISE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && enable && quiet && clrEdgeSel == 2'd0 && $rose(clrIn) |=> !outQ); // R3
  AST_SET_RISE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && enable && quiet && setEdgeSel == 2'd0 && $rose(setIn) && $stable(clrIn) |=> outQ); // R2
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && enable && quiet && clrEdgeSel == 2'd2 && setEdgeSel == 2'd2
    && !$stable(clrIn) && !$stable(setIn) |=> !outQ); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && enable && quiet && $stable(setIn) && $stable(clrIn) |=> $stable(outQ)); // R8
endmodule

bind edge_sr_latch edge_sr_checker u_chk (.*);

// File: tb/sim_edge_sr_latch.sv
module sim_edge_sr_latch;
  localparam int PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst, enable, setIn, clrIn, forceHigh, forceLow;
  logic [1:0] setEdgeSel, clrEdgeSel, idlePolicy;
  logic outQ;

  int vectors = 0;
  int miscompares = 0;
  bit expQ = 1'b0;
  bit prevSet = 1'b0;
  bit prevClr = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  edge_sr_latch u0 (
    .clk(clk), .rst(rst), .enable(enable), .setIn(setIn), .clrIn(clrIn),
    .setEdgeSel(setEdgeSel), .clrEdgeSel(clrEdgeSel), .idlePolicy(idlePolicy),
    .forceHigh(forceHigh), .forceLow(forceLow), .outQ(outQ)
  );

  function automatic bit edgeHit(int sel, bit p, bit c);
    case (sel)
      0: return !p && c;
      1: return p && !c;
      2: return p != c;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, string note);
    vectors++;
    if (outQ !== expQ) begin
      miscompares++;
      $display("FAIL %s (%s): outQ=%0b expected %0b", tag, note, outQ, expQ);
    end
  endtask

  task automatic step(input bit en, input bit s, input bit c, input int ss, input int cs,
                      input int pol, input bit fh, input bit fl, input string note);
    bit nq;
    string tag;
    @(negedge clk);
    enable = en; setIn = s; clrIn = c;
    setEdgeSel = 2'(ss); clrEdgeSel = 2'(cs); idlePolicy = 2'(pol);
    forceHigh = fh; forceLow = fl;
    if (fl)      begin nq = 1'b0; tag = "R6"; end
    else if (fh) begin nq = 1'b1; tag = "R6"; end
    else if (!en) begin
      tag = "R5";
      nq = (pol == 1) ? 1'b1 : (pol == 2) ? expQ : 1'b0;
    end else if (edgeHit(cs, prevClr, c)) begin
      nq = 1'b0;
      tag = edgeHit(ss, prevSet, s) ? "R4" : "R3";
    end else if (edgeHit(ss, prevSet, s)) begin
      nq = 1'b1; tag = "R2";
    end else begin
      nq = expQ; tag = "R8";
    end
    @(posedge clk);
    #(PERIOD/4);
    expQ = nq; prevSet = s; prevClr = c;
    check(tag, note);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; enable = 1'b0; setIn = 1'b0; clrIn = 1'b0;
    setEdgeSel = '0; clrEdgeSel = '0; idlePolicy = '0; forceHigh = 1'b0; forceLow = 1'b0;
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    expQ = 1'b0; prevSet = 1'b0; prevClr = 1'b0;
    check("R1", "reset state");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, cycles=%0d expected fewer", WATCHDOG_CYCLES);
    finishRun();
  end

  initial begin
    rst = 1'b1;
    doReset();

    // R7: select turns to falling together with a rising edge, which is ignored
    step(1, 0, 0, 0, 3, 0, 0, 0, "R7 setup");
    step(1, 1, 0, 1, 3, 0, 0, 0, "R7 rise with select change ignored");
    step(1, 0, 0, 1, 3, 0, 0, 0, "R7 later falling edge sets");
    // R7: select turns to falling together with a falling edge, which is honoured
    step(1, 0, 0, 3, 3, 0, 0, 1, "R7 clear first");
    step(1, 1, 0, 0, 3, 0, 0, 0, "R7 rise with rising select");
    step(1, 1, 0, 0, 3, 0, 0, 1, "R7 clear again");
    step(1, 0, 0, 1, 3, 0, 0, 0, "R7 fall with select change honoured");
    // R9: a level that rose while disabled gives no edge on re-enable
    step(1, 0, 0, 0, 0, 2, 0, 1, "R9 clear");
    step(0, 1, 0, 0, 0, 2, 0, 0, "R9 rise while disabled keep");
    step(1, 1, 0, 0, 0, 2, 0, 0, "R9 re-enable no edge");

    // near-exhaustive sweep, each scored cycle after a disabled setup cycle
    for (int ss = 0; ss < 4; ss++)
      for (int cs = 0; cs < 4; cs++)
        for (int pol = 0; pol < 4; pol++)
          for (int en = 0; en < 2; en++)
            for (int f = 0; f < 4; f++)
              for (int tr = 0; tr < 16; tr++)
                for (int init = 0; init < 2; init++) begin
                  step(0, tr[3], tr[2], (ss + 1) % 4, (cs + 2) % 4, init, 0, 0, "setup");
                  step(en[0], tr[1], tr[0], ss, cs, pol, f[1], f[0], "sweep");
                end

    // R1: reset from a high output
    step(1, 0, 0, 0, 0, 0, 1, 0, "R1 force high before reset");
    doReset();
    finishRun();
  end
endmodule